// File: doc/BRIEF.md
# Level-1 Peripheral Interrupt Controller

This block gathers a wide vector of level-sensitive peripheral interrupt lines. It holds one enable mask for each CPU it serves, and it drives one interrupt request per CPU. The request stays high while any enabled line is active. Lines are grouped into 32-bit words, and the number of words is a parameter. One CPU view of the register space is repeated for each CPU. A source can therefore be steered to any chosen CPU by enabling it only in that CPU's mask.

Software never writes a mask directly. Each CPU view has four banks of `NUM_WORDS` words, placed back to back:

- the live line levels;
- the current mask;
- a write-one-to-enable array;
- a write-one-to-disable array.

Each view starts on a power-of-two boundary. Addresses are word addresses: `addr = cpu * 2**REGION_W + offset`, where `REGION_W = $clog2(4*NUM_WORDS)`.

Top module: `irq_l1_ctrl`

## Requirements
- R1: After reset every mask bit of every CPU is 0, every `irq_o` bit is 0, and mask reads return 0.
- R2: Offsets 0 to N-1 (status bank) return word w of the line levels, `irq_lines_i[32w+31:32w]`, as sampled at the previous clock edge. These words are shared by all CPU views. Writes to them change nothing.
- R3: A write to offset 2N+w (enable bank) sets the mask bits of word w of that CPU wherever the write data has a 1. Bits where the data has a 0 keep their value.
- R4: A write to offset 3N+w (disable bank) clears the mask bits of word w of that CPU wherever the write data has a 1. Bits where the data has a 0 keep their value.
- R5: Offsets N to 2N-1 (mask bank) return mask word w of that CPU. Writes to them leave every mask unchanged.
- R6: Reads of the enable and disable offsets return the current mask word of that CPU.
- R7: `irq_o[c]` is high exactly while some line is high in the sampled status and enabled in CPU c's mask. A line change shows up one clock after it is sampled. A mask write takes effect right after the edge that commits it.
- R8: Each CPU has its own mask. A write in one CPU view leaves the masks of all other CPUs unchanged.
- R9: A read at an offset of 4N or more, or at a CPU index of `NUM_CPUS` or more, returns 0. A write there changes no mask.
- R10: `bus_rdata_o` is 0 whenever `bus_re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 32*NUM_WORDS | Level-sensitive peripheral interrupt lines |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_re_i | input | 1 | Read enable; read data is combinational |
| bus_addr_i | input | REGION_W+CPU_W | Word address: CPU index above the bank offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | NUM_CPUS | One interrupt request per CPU |

## Verification
The bench builds the block with `NUM_WORDS = 5` (160 lines) and `NUM_CPUS = 3`. With these values the bank boundaries are not powers of two, so offsets 20 to 31 of each view are holes. The value also leaves CPU index 3 unused, so both kinds of out-of-range access can be exercised. Three CPU views are enough to show that a write in one view leaves the other two views untouched. The top word reaches line 159, the highest line.

// File: rtl/irq_l1_pkg.sv
package irq_l1_pkg;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    BANK_STATUS = 2'd0,
    BANK_MASK   = 2'd1,
    BANK_SET    = 2'd2,
    BANK_CLR    = 2'd3
  } bank_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_l1_addr_dec.sv
module irq_l1_addr_dec
  import irq_l1_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_CPUS  = 2,
  localparam int unsigned REGION_W = $clog2(4 * NUM_WORDS),
  localparam int unsigned CPU_W    = idx_w(NUM_CPUS),
  localparam int unsigned WORD_W   = idx_w(NUM_WORDS),
  localparam int unsigned ADDR_W   = REGION_W + CPU_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output bank_e             bank_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CPU_W-1:0]  cpu_o
);
  logic [REGION_W-1:0] off;
  int unsigned off_u, cpu_u, base;

  assign off   = addr_i[REGION_W-1:0];
  assign cpu_o = addr_i[ADDR_W-1:REGION_W];

  always_comb begin
    off_u = 32'(off);
    cpu_u = 32'(cpu_o);
    hit_o = (off_u < 4 * NUM_WORDS) && (cpu_u < NUM_CPUS);
    if (off_u < NUM_WORDS) begin
      bank_o = BANK_STATUS;
      base   = 0;
    end else if (off_u < 2 * NUM_WORDS) begin
      bank_o = BANK_MASK;
      base   = NUM_WORDS;
    end else if (off_u < 3 * NUM_WORDS) begin
      bank_o = BANK_SET;
      base   = 2 * NUM_WORDS;
    end else begin
      bank_o = BANK_CLR;
      base   = 3 * NUM_WORDS;
    end
    word_o = WORD_W'(off_u - base);
  end
endmodule

// File: rtl/irq_l1_line_sample.sv
module irq_l1_line_sample #(
  parameter int unsigned NUM_LINES = 96
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= lines_i;
  end
endmodule

// File: rtl/irq_l1_mask_bank.sv
module irq_l1_mask_bank
  import irq_l1_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  localparam int unsigned WORD_W    = idx_w(NUM_WORDS),
  localparam int unsigned NUM_LINES = NUM_WORDS * WORD_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_en_i,
  input  logic                 clr_en_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [WORD_BITS-1:0] wdata_i,
  input  logic [NUM_LINES-1:0] status_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] set_vec, clr_vec, mask_d;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic word_hit;
    assign word_hit = (word_i == WORD_W'(w));
    assign set_vec[w*WORD_BITS +: WORD_BITS] = (set_en_i && word_hit) ? wdata_i : '0;
    assign clr_vec[w*WORD_BITS +: WORD_BITS] = (clr_en_i && word_hit) ? wdata_i : '0;
  end

  // clear applied last: a bit hit by both ends disabled
  assign mask_d = (mask_o | set_vec) & ~clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= mask_d;
  end

  assign irq_o = |(status_i & mask_o);
endmodule

// File: rtl/irq_l1_ctrl.sv
module irq_l1_ctrl
  import irq_l1_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_CPUS  = 2,
  localparam int unsigned NUM_LINES = NUM_WORDS * WORD_BITS,
  localparam int unsigned REGION_W  = $clog2(4 * NUM_WORDS),
  localparam int unsigned CPU_W     = idx_w(NUM_CPUS),
  localparam int unsigned WORD_W    = idx_w(NUM_WORDS),
  localparam int unsigned ADDR_W    = REGION_W + CPU_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_we_i,
  input  logic                 bus_re_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [WORD_BITS-1:0] bus_wdata_i,
  output logic [WORD_BITS-1:0] bus_rdata_o,
  output logic [NUM_CPUS-1:0]  irq_o
);
  logic                          dec_hit;
  bank_e                         dec_bank;
  logic [WORD_W-1:0]             dec_word;
  logic [CPU_W-1:0]              dec_cpu;
  logic [NUM_LINES-1:0]          status_q;
  logic [NUM_CPUS*NUM_LINES-1:0] mask_all;
  logic                          wr_set, wr_clr;

  irq_l1_addr_dec #(.NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)) u_dec (
    .addr_i (bus_addr_i),
    .hit_o  (dec_hit),
    .bank_o (dec_bank),
    .word_o (dec_word),
    .cpu_o  (dec_cpu)
  );

  irq_l1_line_sample #(.NUM_LINES(NUM_LINES)) u_sample (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (irq_lines_i),
    .status_o (status_q)
  );

  assign wr_set = bus_we_i && dec_hit && (dec_bank == BANK_SET);
  assign wr_clr = bus_we_i && dec_hit && (dec_bank == BANK_CLR);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic cpu_sel;
    assign cpu_sel = (dec_cpu == CPU_W'(c));

    irq_l1_mask_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_en_i (wr_set && cpu_sel),
      .clr_en_i (wr_clr && cpu_sel),
      .word_i   (dec_word),
      .wdata_i  (bus_wdata_i),
      .status_i (status_q),
      .mask_o   (mask_all[c*NUM_LINES +: NUM_LINES]),
      .irq_o    (irq_o[c])
    );
  end

  logic [WORD_BITS-1:0] status_word, mask_word;

  always_comb begin
    status_word = '0;
    mask_word   = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (dec_word == WORD_W'(w)) status_word = status_q[w*WORD_BITS +: WORD_BITS];
    end
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (dec_cpu == CPU_W'(c) && dec_word == WORD_W'(w))
          mask_word = mask_all[c*NUM_LINES + w*WORD_BITS +: WORD_BITS];
      end
    end
    bus_rdata_o = '0;
    if (bus_re_i && dec_hit)
      bus_rdata_o = (dec_bank == BANK_STATUS) ? status_word : mask_word;
  end
endmodule

// File: rtl/irq_l1_ctrl_chk.sv
module irq_l1_ctrl_chk
  import irq_l1_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned NUM_CPUS  = 2,
  localparam int unsigned NUM_LINES = NUM_WORDS * WORD_BITS,
  localparam int unsigned REGION_W  = $clog2(4 * NUM_WORDS),
  localparam int unsigned CPU_W     = idx_w(NUM_CPUS),
  localparam int unsigned ADDR_W    = REGION_W + CPU_W
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_LINES-1:0]          irq_lines_i,
  input logic                          bus_we_i,
  input logic                          bus_re_i,
  input logic [ADDR_W-1:0]             bus_addr_i,
  input logic [WORD_BITS-1:0]          bus_wdata_i,
  input logic [WORD_BITS-1:0]          bus_rdata_o,
  input logic [NUM_CPUS-1:0]           irq_o,
  input logic [NUM_CPUS*NUM_LINES-1:0] mask_flat
);
  int unsigned c_off, c_cpu, c_base, prev_base;
  logic set_hit, clr_hit;
  logic [WORD_BITS-1:0] prev_wdata;

  always_comb begin
    c_off   = 32'(bus_addr_i[REGION_W-1:0]);
    c_cpu   = 32'(bus_addr_i >> REGION_W);
    set_hit = bus_we_i && (c_cpu < NUM_CPUS) && (c_off >= 2*NUM_WORDS) && (c_off < 3*NUM_WORDS);
    clr_hit = bus_we_i && (c_cpu < NUM_CPUS) && (c_off >= 3*NUM_WORDS) && (c_off < 4*NUM_WORDS);
    c_base  = 0;
    if (set_hit) c_base = c_cpu*NUM_LINES + (c_off - 2*NUM_WORDS)*WORD_BITS;
    if (clr_hit) c_base = c_cpu*NUM_LINES + (c_off - 3*NUM_WORDS)*WORD_BITS;
  end

  always_ff @(posedge clk_i) begin
    prev_base  <= c_base;
    prev_wdata <= bus_wdata_i;
  end

  p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (mask_flat == '0 && irq_o == '0));

  p_set_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_hit |=> ((mask_flat[prev_base +: WORD_BITS] & prev_wdata) == prev_wdata));

  p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> ((mask_flat[prev_base +: WORD_BITS] & prev_wdata) == '0));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_hit || clr_hit) |=> $stable(mask_flat));

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(|irq_lines_i));

  p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |-> (bus_rdata_o == '0));
endmodule

bind irq_l1_ctrl irq_l1_ctrl_chk #(.NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .mask_flat   (mask_all)
);

// File: tb/irq_l1_ctrl_bench.sv
module irq_l1_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q  = CLK_PERIOD / 4;
  localparam int NW = 5;
  localparam int NC = 3;
  localparam int NL = NW * 32;
  localparam int AW = 7;   // 5 offset bits + 2 cpu bits

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic [NL-1:0] lines;
  logic          we, re;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [NC-1:0] irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit model_on = 1'b0;

  irq_l1_ctrl #(.NUM_WORDS(NW), .NUM_CPUS(NC)) u_irq_l1_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_lines_i (lines),
    .bus_we_i    (we),
    .bus_re_i    (re),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference
  logic [31:0] m_mask [NC][NW];
  logic [31:0] m_stat [NW];

  always @(posedge clk or negedge rst_n) begin
    int cpu, off;
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) m_mask[c][w] = '0;
      for (int w = 0; w < NW; w++) m_stat[w] = '0;
    end else begin
      cpu = int'(addr) / 32;
      off = int'(addr) % 32;
      if (we && cpu < NC && off >= 2*NW && off < 4*NW) begin
        if (off < 3*NW) m_mask[cpu][off % NW] = m_mask[cpu][off % NW] | wdata;
        else            m_mask[cpu][off % NW] = m_mask[cpu][off % NW] & ~wdata;
      end
      for (int w = 0; w < NW; w++) m_stat[w] = lines[w*32 +: 32];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    int cpu, off;
    cpu = int'(a) / 32;
    off = int'(a) % 32;
    if (cpu >= NC || off >= 4*NW) return '0;
    if (off < NW) return m_stat[off];
    return m_mask[cpu][off % NW];
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((m_stat[w] & m_mask[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  function automatic string tag_of(input logic r, input logic [AW-1:0] a);
    int cpu, off;
    cpu = int'(a) / 32;
    off = int'(a) % 32;
    if (!r) return "R10 idle read";
    if (cpu >= NC || off >= 4*NW) return "R9 hole read";
    if (off < NW) return "R2 status read";
    if (off < 2*NW) return "R5 mask read";
    return "R6 set/clear read";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !done) begin
      check("R7 irq vs model", 32'(irq), 32'(exp_irq()));
      check(tag_of(re, addr), rdata, re ? exp_rd(addr) : 32'h0);
    end
  end

  task automatic drive(input logic w, input logic r, input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk);
    #(Q);
    we = w; re = r; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    drive(1'b1, 1'b0, a, d);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    drive(1'b0, 1'b1, a, 32'h0);
    @(negedge clk);
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic set_lines(input logic [NL-1:0] v);
    @(posedge clk);
    #(Q);
    lines = v; we = 1'b0; re = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    logic [NL-1:0] pat;
    rst_n = 1'b0; lines = '0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #(Q);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    check("R1 irq after reset", 32'(irq), 32'h0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        rd_chk(AW'(c*32 + NW + w), 32'h0, "R1 mask after reset");

    // R2 status words
    for (int w = 0; w < NW; w++) pat[w*32 +: 32] = 32'h1357_9BDF ^ (32'(w) * 32'h0101_0101);
    set_lines(pat);
    for (int w = 0; w < NW; w++) rd_chk(AW'(w), pat[w*32 +: 32], "R2 status level");
    wr(AW'(2), 32'hFFFF_FFFF);
    rd_chk(AW'(2), pat[2*32 +: 32], "R2 status write ignored");
    rd_chk(AW'(32 + 1), pat[1*32 +: 32], "R2 status shared by cpu1");
    set_lines('0);

    // R3 enable bank
    wr(AW'(2*NW + 1), 32'h0000_00F0);
    rd_chk(AW'(NW + 1), 32'h0000_00F0, "R3 set bits");
    wr(AW'(2*NW + 1), 32'h0000_000F);
    rd_chk(AW'(NW + 1), 32'h0000_00FF, "R3 zero bits keep");

    // R4 disable bank
    wr(AW'(3*NW + 1), 32'h0000_0030);
    rd_chk(AW'(NW + 1), 32'h0000_00CF, "R4 clear bits");
    wr(AW'(3*NW + 1), 32'h0);
    rd_chk(AW'(NW + 1), 32'h0000_00CF, "R4 zero bits keep");

    // R5 mask bank read-only
    wr(AW'(NW + 1), 32'hFFFF_FFFF);
    rd_chk(AW'(NW + 1), 32'h0000_00CF, "R5 mask write ignored");
    wr(AW'(NW + 2), 32'hFFFF_FFFF);
    rd_chk(AW'(NW + 2), 32'h0, "R5 mask write ignored other word");

    // R6 set/clear reads
    rd_chk(AW'(2*NW + 1), 32'h0000_00CF, "R6 set addr reads mask");
    rd_chk(AW'(3*NW + 1), 32'h0000_00CF, "R6 clear addr reads mask");

    // R8 per-cpu masks
    rd_chk(AW'(32 + NW + 1), 32'h0, "R8 cpu1 untouched");
    wr(AW'(32 + 2*NW + 4), 32'h8000_0000);
    rd_chk(AW'(32 + NW + 4), 32'h8000_0000, "R8 cpu1 set");
    rd_chk(AW'(NW + 4), 32'h0, "R8 cpu0 untouched");
    rd_chk(AW'(64 + NW + 4), 32'h0, "R8 cpu2 untouched");

    // R7 irq timing
    set_lines('0);
    @(negedge clk); #1;
    check("R7 idle irq", 32'(irq), 32'h0);
    pat = '0; pat[32] = 1'b1; pat[159] = 1'b1;
    set_lines(pat);
    @(negedge clk); #1;
    check("R7 one-cycle latency", 32'(irq), 32'h0);
    @(negedge clk); #1;
    check("R7 irq per cpu routing", 32'(irq), 32'b011);
    wr(AW'(3*NW + 1), 32'h0000_0001);
    @(negedge clk); #1;
    check("R7 before mask commit", 32'(irq), 32'b011);
    drive(1'b0, 1'b0, '0, '0);
    @(negedge clk); #1;
    check("R7 mask clear drops irq", 32'(irq), 32'b010);
    set_lines('0);

    // R9 holes
    rd_chk(AW'(4*NW), 32'h0, "R9 offset hole");
    rd_chk(AW'(31), 32'h0, "R9 top offset hole");
    rd_chk(AW'(96 + NW + 1), 32'h0, "R9 cpu hole");
    wr(AW'(96 + 2*NW + 1), 32'hFFFF_FFFF);
    wr(AW'(4*NW + 1), 32'hFFFF_FFFF);
    rd_chk(AW'(NW + 1), 32'h0000_00CE, "R9 hole write no effect cpu0");
    rd_chk(AW'(32 + NW + 1), 32'h0, "R9 hole write no effect cpu1");

    // R10 idle read
    drive(1'b0, 1'b0, AW'(NW + 1), 32'h0);
    @(negedge clk); #1;
    check("R10 no read enable", rdata, 32'h0);

    // mixed traffic, compared against the model every clock (R2-R10)
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      #(Q);
      for (int w = 0; w < NW; w++) lines[w*32 +: 32] = $urandom & $urandom & $urandom;
      we    = ($urandom % 3) == 0;
      re    = ($urandom % 2) == 0;
      addr  = AW'($urandom % 128);
      wdata = $urandom;
    end
    drive(1'b0, 1'b0, '0, '0);
    @(negedge clk); #1;

    done = 1'b1;
    finish_run();
  end
endmodule